// File: doc/BRIEF.md
# Two-Host Doorbell Mailbox

This block carries request/acknowledge signalling between two hosts that share a system. One host sits on a byte-wide parallel port. The other sits on a 16-bit multiplexed IO bus. Each host has a write-only command word and a read-only 4-bit status. Bus handshakes and address decoding are done elsewhere. The block receives one-cycle command-write strobes with the command value, and it returns each host's status word and interrupt level.

There are four flags: a request and an acknowledge for each host. A host can only set its own two flags. It sees the other host's flags in the upper half of its status, and either of them raises its interrupt. When a host has handled the other host's event, it retires it with a clear command. A wipe command, or the IO-bus reset input, returns every flag to zero. All storage is in one clock domain. Every result is registered and becomes visible one clock after the strobe.

Top module: `dbell_mbox`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, both status words read 0000, `iob_irq` is 0 and `pp_irq_n` is 1.
- R2: A strobed command with bit 0 set sets the writer's own request flag. Bit 1 set sets the writer's own acknowledge flag. The change is visible one clock after the strobe.
- R3: In each status word, bit 0 is the reader's own request and bit 1 is its own acknowledge. Bit 2 is the other host's request and bit 3 is the other host's acknowledge.
- R4: A strobed command with bits 3:2 equal to 11 clears both of the other host's flags, which are the flags in the writer's status bits 3:2. The values 01 and 10 in bits 3:2 clear nothing.
- R5: A strobed command with bit 6 set, from either host, clears all four flags.
- R6: If a set and a clear (bits 3:2 or bit 6, from either host) hit the same flag in the same cycle, the flag ends up set.
- R7: `iob_irq` (active high) is 1 exactly when status bits 3:2 of the IO-bus host are not 00. `pp_irq_n` (active low) is 0 exactly when status bits 3:2 of the parallel-port host are not 00. Both change in the same cycle as the status.
- R8: While `iob_rst` is high, all flags clear one clock later and stay clear, both interrupts are idle, and command strobes are ignored.
- R9: A command value presented while its strobe is low changes nothing.
- R10: Sequence: the parallel-port host requests, and the IO-bus host then reads 0100 with `iob_irq`=1. After both hosts request and both acknowledge, the IO-bus host reads 1111. A clear from the parallel-port host makes it read 0011 with `pp_irq_n`=1. A clear from the IO-bus host then makes it read 0000 with `iob_irq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iob_rst | input | 1 | IO-bus reset, active high; holds all flags clear |
| pp_cmd_we | input | 1 | One-cycle command strobe from the parallel-port host |
| pp_cmd | input | PP_CMD_W | Parallel-port command value |
| iob_cmd_we | input | 1 | One-cycle command strobe from the IO-bus host |
| iob_cmd | input | IOB_CMD_W | IO-bus command value |
| pp_sts | output | 4 | Status seen by the parallel-port host |
| pp_irq_n | output | 1 | Parallel-port interrupt, active low |
| iob_sts | output | 4 | Status seen by the IO-bus host |
| iob_irq | output | 1 | IO-bus interrupt, active high |

## Verification
Every result is due exactly one rising edge after its cause. This covers flag sets, clears, the wipe, the `iob_rst` hold, and the interrupt levels, which are registered from the flags' next state. The bench drives strobes on falling edges. After each operation it samples the outputs on the next falling edge, which lies half a clock after the edge that captured the strobe. The bench's behavioural model updates on rising edges and is compared with both status words and both interrupts on every falling edge. So a result that comes one cycle early or one cycle late shows up as a mismatch.

// File: rtl/dbm_pkg.sv
package dbm_pkg;
  localparam int NSIDE          = 2;
  localparam int FLAGS_PER_SIDE = 2;
  localparam int NFLAG          = NSIDE * FLAGS_PER_SIDE;
  localparam int STS_W          = NFLAG;

  // command bit positions (shared encoding for both hosts)
  localparam int BIT_REQ    = 0;
  localparam int BIT_ACK    = 1;
  localparam int BIT_CLR_LO = 2;
  localparam int BIT_CLR_HI = 3;
  localparam int BIT_WIPE   = 6;
  localparam int MIN_CMD_W  = BIT_WIPE + 1;

  // side indices
  localparam int SIDE_PP  = 0;
  localparam int SIDE_IOB = 1;

  typedef struct packed {
    logic                      wipe;
    logic                      clr_peer;
    logic [FLAGS_PER_SIDE-1:0] set;
  } dbm_op_t;

  localparam dbm_op_t OP_NONE = '0;
endpackage

// File: rtl/dbm_cmd_dec.sv
module dbm_cmd_dec
  import dbm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         we,
  input  logic [W-1:0] cmd,
  output dbm_op_t      op
);
  localparam int SPARE_W = W - MIN_CMD_W;

  always_comb begin
    op = OP_NONE;
    if (we) begin
      op.set[BIT_REQ] = cmd[BIT_REQ];
      op.set[BIT_ACK] = cmd[BIT_ACK];
      op.clr_peer     = cmd[BIT_CLR_HI] & cmd[BIT_CLR_LO];
      op.wipe         = cmd[BIT_WIPE];
    end
  end

  // bits with no meaning in the command encoding
  logic unused_bits;
  if (SPARE_W > 0) begin : g_spare
    assign unused_bits = ^{cmd[W-1:MIN_CMD_W], cmd[BIT_WIPE-1:BIT_CLR_HI+1]};
  end else begin : g_nospare
    assign unused_bits = ^cmd[BIT_WIPE-1:BIT_CLR_HI+1];
  end
endmodule

// File: rtl/dbm_flag_bank.sv
module dbm_flag_bank
  import dbm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  dbm_op_t          ops [NSIDE],
  output logic [NFLAG-1:0] flags_q,
  output logic [NFLAG-1:0] flags_d
);
  logic wipe_any;

  always_comb begin
    wipe_any = 1'b0;
    for (int s = 0; s < NSIDE; s++) wipe_any = wipe_any | ops[s].wipe;
  end

  for (genvar f = 0; f < NFLAG; f++) begin : g_flag
    localparam int OWNER = f / FLAGS_PER_SIDE;
    localparam int PEER  = NSIDE - 1 - OWNER;
    localparam int FBIT  = f % FLAGS_PER_SIDE;

    logic set_f, clr_f, nxt_f;

    // owner may only set, the peer may only clear; set has priority
    assign set_f = ops[OWNER].set[FBIT];
    assign clr_f = ops[PEER].clr_peer | wipe_any;
    assign nxt_f = set_f | (flags_q[f] & ~clr_f);
    assign flags_d[f] = hold ? 1'b0 : nxt_f;

    always_ff @(posedge clk) begin
      if (rst) flags_q[f] <= 1'b0;
      else     flags_q[f] <= flags_d[f];
    end
  end
endmodule

// File: rtl/dbm_view.sv
module dbm_view
  import dbm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] flags_q,
  input  logic [NFLAG-1:0] flags_d,
  output logic [STS_W-1:0] pp_sts,
  output logic [STS_W-1:0] iob_sts,
  output logic             pp_irq_n,
  output logic             iob_irq
);
  localparam int PP_LO  = SIDE_PP * FLAGS_PER_SIDE;
  localparam int IOB_LO = SIDE_IOB * FLAGS_PER_SIDE;

  // own flags in the low half, peer flags in the high half
  assign pp_sts  = {flags_q[IOB_LO +: FLAGS_PER_SIDE], flags_q[PP_LO +: FLAGS_PER_SIDE]};
  assign iob_sts = {flags_q[PP_LO +: FLAGS_PER_SIDE], flags_q[IOB_LO +: FLAGS_PER_SIDE]};

  // interrupts registered from next-state flags so they align with status
  always_ff @(posedge clk) begin
    if (rst) begin
      pp_irq_n <= 1'b1;
      iob_irq  <= 1'b0;
    end else begin
      pp_irq_n <= ~(|flags_d[IOB_LO +: FLAGS_PER_SIDE]);
      iob_irq  <=   |flags_d[PP_LO +: FLAGS_PER_SIDE];
    end
  end
endmodule

// File: rtl/dbell_mbox.sv
module dbell_mbox
  import dbm_pkg::*;
#(
  parameter int PP_CMD_W  = 8,
  parameter int IOB_CMD_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 iob_rst,
  input  logic                 pp_cmd_we,
  input  logic [PP_CMD_W-1:0]  pp_cmd,
  input  logic                 iob_cmd_we,
  input  logic [IOB_CMD_W-1:0] iob_cmd,
  output logic [3:0]           pp_sts,
  output logic                 pp_irq_n,
  output logic [3:0]           iob_sts,
  output logic                 iob_irq
);
  dbm_op_t          ops [NSIDE];
  logic [NFLAG-1:0] flags_q;
  logic [NFLAG-1:0] flags_d;

  dbm_cmd_dec #(.W(PP_CMD_W)) u_dec_pp (
    .we (pp_cmd_we),
    .cmd(pp_cmd),
    .op (ops[SIDE_PP])
  );

  dbm_cmd_dec #(.W(IOB_CMD_W)) u_dec_iob (
    .we (iob_cmd_we),
    .cmd(iob_cmd),
    .op (ops[SIDE_IOB])
  );

  dbm_flag_bank u_bank (
    .clk    (clk),
    .rst    (rst),
    .hold   (iob_rst),
    .ops    (ops),
    .flags_q(flags_q),
    .flags_d(flags_d)
  );

  dbm_view u_view (
    .clk     (clk),
    .rst     (rst),
    .flags_q (flags_q),
    .flags_d (flags_d),
    .pp_sts  (pp_sts),
    .iob_sts (iob_sts),
    .pp_irq_n(pp_irq_n),
    .iob_irq (iob_irq)
  );
endmodule

// File: rtl/dbm_checker.sv
module dbm_checker #(
  parameter int PP_W  = 8,
  parameter int IOB_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             iob_rst,
  input logic             pp_cmd_we,
  input logic [PP_W-1:0]  pp_cmd,
  input logic             iob_cmd_we,
  input logic [IOB_W-1:0] iob_cmd,
  input logic [3:0]       pp_sts,
  input logic             pp_irq_n,
  input logic [3:0]       iob_sts,
  input logic             iob_irq
);
  logic pp_wipe, iob_wipe;
  assign pp_wipe  = pp_cmd_we && pp_cmd[6];
  assign iob_wipe = iob_cmd_we && iob_cmd[6];

  // R1: idle outputs right after reset is released
  p_rst_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pp_sts == 4'b0 && iob_sts == 4'b0 && !iob_irq && pp_irq_n));

  // R2: own request set by command bit 0
  p_set_req_r2: assert property (@(posedge clk) disable iff (rst)
    (pp_cmd_we && pp_cmd[0] && !iob_rst) |=> pp_sts[0]);

  // R4: clear of peer flags from the parallel-port host
  p_clr_peer_r4: assert property (@(posedge clk) disable iff (rst)
    (pp_cmd_we && pp_cmd[3:2] == 2'b11 && !(iob_cmd_we && iob_cmd[1:0] != 2'b00))
      |=> pp_sts[3:2] == 2'b00);

  // R5: wipe from either host with no set pending clears everything
  p_wipe_r5: assert property (@(posedge clk) disable iff (rst)
    ((pp_wipe || iob_wipe) && !(pp_cmd_we && pp_cmd[1:0] != 2'b00)
      && !(iob_cmd_we && iob_cmd[1:0] != 2'b00)) |=> (pp_sts == 4'b0 && iob_sts == 4'b0));

  // R6: set beats a simultaneous clear from the peer
  p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (iob_cmd_we && iob_cmd[1] && pp_cmd_we && pp_cmd[3:2] == 2'b11 && !iob_rst)
      |=> iob_sts[1]);

  // R7: interrupts follow the peer half of the status
  p_iob_irq_r7: assert property (@(posedge clk) disable iff (rst)
    iob_irq == (iob_sts[3:2] != 2'b00));
  p_pp_irq_r7: assert property (@(posedge clk) disable iff (rst)
    pp_irq_n == (pp_sts[3:2] == 2'b00));

  // R8: IO-bus reset forces idle
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    iob_rst |=> (pp_sts == 4'b0 && iob_sts == 4'b0 && !iob_irq && pp_irq_n));

  // R9: no strobe, no change
  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (!pp_cmd_we && !iob_cmd_we && !iob_rst) |=> ($stable(pp_sts) && $stable(iob_sts)));
endmodule

bind dbell_mbox dbm_checker #(.PP_W(PP_CMD_W), .IOB_W(IOB_CMD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .iob_rst   (iob_rst),
  .pp_cmd_we (pp_cmd_we),
  .pp_cmd    (pp_cmd),
  .iob_cmd_we(iob_cmd_we),
  .iob_cmd   (iob_cmd),
  .pp_sts    (pp_sts),
  .pp_irq_n  (pp_irq_n),
  .iob_sts   (iob_sts),
  .iob_irq   (iob_irq)
);

// File: tb/tb_dbell_mbox.sv
`timescale 1ns/1ps
module tb_dbell_mbox;
  localparam int PP_W  = 8;
  localparam int IOB_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             iob_rst = 1'b0;
  logic             pp_cmd_we = 1'b0;
  logic [PP_W-1:0]  pp_cmd = '0;
  logic             iob_cmd_we = 1'b0;
  logic [IOB_W-1:0] iob_cmd = '0;
  logic [3:0]       pp_sts, iob_sts;
  logic             pp_irq_n, iob_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit started = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  dbell_mbox #(.PP_CMD_W(PP_W), .IOB_CMD_W(IOB_W)) dut (
    .clk(clk), .rst(rst), .iob_rst(iob_rst),
    .pp_cmd_we(pp_cmd_we), .pp_cmd(pp_cmd),
    .iob_cmd_we(iob_cmd_we), .iob_cmd(iob_cmd),
    .pp_sts(pp_sts), .pp_irq_n(pp_irq_n),
    .iob_sts(iob_sts), .iob_irq(iob_irq)
  );

  // behavioural model: m[0] pp req, m[1] pp ack, m[2] iob req, m[3] iob ack
  bit [3:0] m = '0;

  always @(posedge clk) begin
    bit [3:0] nm;
    started = 1'b1;
    if (rst || iob_rst) begin
      m = '0;
    end else begin
      nm = m;
      if ((pp_cmd_we && pp_cmd[6]) || (iob_cmd_we && iob_cmd[6])) nm = '0;
      if (iob_cmd_we && iob_cmd[3:2] == 2'b11) nm[1:0] = 2'b00;
      if (pp_cmd_we && pp_cmd[3:2] == 2'b11)   nm[3:2] = 2'b00;
      if (pp_cmd_we) begin
        if (pp_cmd[0]) nm[0] = 1'b1;
        if (pp_cmd[1]) nm[1] = 1'b1;
      end
      if (iob_cmd_we) begin
        if (iob_cmd[0]) nm[2] = 1'b1;
        if (iob_cmd[1]) nm[3] = 1'b1;
      end
      m = nm;
    end
  end

  // compare against the model on every falling edge
  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (pp_sts !== {m[3], m[2], m[1], m[0]} || iob_sts !== {m[1], m[0], m[3], m[2]}) begin
        errors++;
        $display("FAIL R3 model status pp=%b iob=%b expected pp=%b iob=%b",
                 pp_sts, iob_sts, {m[3], m[2], m[1], m[0]}, {m[1], m[0], m[3], m[2]});
      end
      checks++;
      if (iob_irq !== (m[0] | m[1]) || pp_irq_n !== !(m[2] | m[3])) begin
        errors++;
        $display("FAIL R7 model irq iob_irq=%b pp_irq_n=%b expected %b %b",
                 iob_irq, pp_irq_n, m[0] | m[1], !(m[2] | m[3]));
      end
    end
  end

  task automatic chk4(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic chk1(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic both_wr(bit pw, logic [7:0] pc, bit iw, logic [15:0] ic);
    @(negedge clk);
    pp_cmd_we = pw; pp_cmd = pc;
    iob_cmd_we = iw; iob_cmd = ic;
    @(negedge clk);
    pp_cmd_we = 1'b0; iob_cmd_we = 1'b0;
  endtask

  task automatic pp_wr(logic [7:0] c);
    both_wr(1'b1, c, 1'b0, '0);
  endtask

  task automatic iob_wr(logic [15:0] c);
    both_wr(1'b0, '0, 1'b1, c);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk4("R1 pp_sts in reset", pp_sts, 4'b0000);
    rst = 1'b0;
    @(negedge clk);
    chk4("R1 iob_sts after reset", iob_sts, 4'b0000);
    chk1("R1 iob_irq after reset", iob_irq, 1'b0);
    chk1("R1 pp_irq_n after reset", pp_irq_n, 1'b1);

    // R10 handshake sequence, also covers R2 and R3
    pp_wr(8'h01);
    chk4("R10 iob sees peer request", iob_sts, 4'b0100);
    chk1("R10 iob_irq after peer request", iob_irq, 1'b1);
    chk4("R2 pp own request", pp_sts, 4'b0001);
    iob_wr(16'h0001);
    chk4("R3 pp sees both requests", pp_sts, 4'b0101);
    chk1("R7 pp_irq_n low on peer request", pp_irq_n, 1'b0);
    pp_wr(8'h02);
    chk4("R2 pp own acknowledge", pp_sts, 4'b0111);
    iob_wr(16'h0002);
    chk4("R10 iob reads all set", iob_sts, 4'b1111);
    pp_wr(8'h0C);
    chk4("R10 pp after clear", pp_sts, 4'b0011);
    chk1("R10 pp_irq_n after clear", pp_irq_n, 1'b1);
    chk4("R4 iob own flags cleared", iob_sts, 4'b1100);
    iob_wr(16'h000C);
    chk4("R10 iob after clear", iob_sts, 4'b0000);
    chk1("R10 iob_irq after clear", iob_irq, 1'b0);

    // R4 partial clear codes have no effect
    pp_wr(8'h01);
    iob_wr(16'h0004);
    chk4("R4 code 01 ignored", iob_sts, 4'b0100);
    iob_wr(16'h0008);
    chk4("R4 code 10 ignored", iob_sts, 4'b0100);

    // R9 command without strobe
    both_wr(1'b0, 8'h4C, 1'b0, 16'h004C);
    chk4("R9 unstrobed command", iob_sts, 4'b0100);
    chk1("R9 irq unchanged", iob_irq, 1'b1);

    // R6 set beats clear
    iob_wr(16'h000C);
    chk4("R4 iob clears pp flags", iob_sts, 4'b0000);
    both_wr(1'b1, 8'h01, 1'b1, 16'h000C);
    chk4("R6 set wins over peer clear", iob_sts, 4'b0100);
    both_wr(1'b1, 8'h40, 1'b1, 16'h0002);
    chk4("R6 set wins over wipe", iob_sts, 4'b0010);
    chk4("R5 wipe clears pp request", pp_sts, 4'b1000);

    // R5 wipe from each side
    both_wr(1'b1, 8'h03, 1'b1, 16'h0003);
    chk4("R5 all set before wipe", pp_sts, 4'b1111);
    pp_wr(8'h40);
    chk4("R5 wipe from pp", pp_sts, 4'b0000);
    both_wr(1'b1, 8'h03, 1'b1, 16'h0003);
    iob_wr(16'h0040);
    chk4("R5 wipe from iob", iob_sts, 4'b0000);

    // R8 IO-bus reset
    both_wr(1'b1, 8'h03, 1'b1, 16'h0003);
    @(negedge clk);
    iob_rst = 1'b1;
    @(negedge clk);
    chk4("R8 flags cleared by iob_rst", pp_sts, 4'b0000);
    chk1("R8 pp_irq_n idle", pp_irq_n, 1'b1);
    chk1("R8 iob_irq idle", iob_irq, 1'b0);
    both_wr(1'b1, 8'h03, 1'b1, 16'h0003);
    chk4("R8 strobes ignored during iob_rst", iob_sts, 4'b0000);
    iob_rst = 1'b0;
    @(negedge clk);
    chk4("R8 still clear after release", pp_sts, 4'b0000);

    // mixed patterns checked against the model
    for (int i = 0; i < 96; i++) begin
      logic [7:0]  pc;
      logic [15:0] ic;
      pc = 8'((i * 29 + 3) & 8'h0F);
      ic = 16'((i * 53 + 7) & 16'h000F);
      if (i % 11 == 10) pc[6] = 1'b1;
      if (i % 13 == 12) ic[6] = 1'b1;
      both_wr(i % 3 != 0, pc, i % 4 != 1, ic);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule